// File: doc/BRIEF.md
# Parallel-Load Shift Register with Shift Inhibit

This block is a parallel-in, serial-out shift register of `N` stages (eight by default). It is modelled synchronously to a fast system clock. An active-low load control takes a full word from the parallel inputs while it is low. That control is level-sensitive, so it holds the register on the parallel word for as long as it stays low. While the control is high, the register moves one stage toward its last stage on each rising edge of an effective shift clock. A serial input enters the first stage on each shift. The last stage is driven out both as it is and inverted.

The effective shift clock is the OR of two interchangeable inputs: a shift clock and a shift inhibit. A rising edge on either one, while the other is low, produces a shift. While either one is held high, the other can toggle freely without effect. All inputs pass through the same synchroniser chain of `SYNC_STAGES` flops, so control and data stay aligned. No handshake exists at the edges: every pin is a plain level, and no data stream or back-pressure is involved. Each input must simply be held for at least `SYNC_STAGES + 1` system cycles.

Top module: `piso_shift_inh`

## Requirements
- R1: While `rst_n` is low at a system clock edge, every stage clears to 0, so that `q_o` is 0 and `q_n_o` is 1.
- R2: While `load_n_i` is low, the stages take `par_i`, with `par_i[0]` going into the first stage and `par_i[N-1]` into the last stage, which drives `q_o`.
- R3: While `load_n_i` is low, the levels and edges of `sclk_i`, `hold_i` and `ser_i` do not change the stages. A load and a shift edge that reach the register in the same cycle resolve to the load.
- R4: With `load_n_i` high, a rising edge of `sclk_i` while `hold_i` is low shifts once. The first stage takes `ser_i`, and each other stage takes the value of its lower neighbour.
- R5: With `load_n_i` high, a rising edge of `hold_i` while `sclk_i` is low also shifts once, in the same way as R4.
- R6: While either `sclk_i` or `hold_i` is high, toggling the other input causes no shift.
- R7: Falling edges and steady levels of `sclk_i` and `hold_i` cause no shift. At most one shift happens per rising edge of their OR.
- R8: `q_n_o` is always the inverse of `q_o`.
- R9: An input change first shows at `q_o` after the third rising system clock edge that follows it (two synchroniser flops plus the stage register), and not earlier.
- R10: While `load_n_i` is high, changes on `par_i` have no effect on the stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_n_i | input | 1 | Low: parallel load (level); high: shift mode |
| sclk_i | input | 1 | Shift clock, rising edge active |
| hold_i | input | 1 | Shift inhibit, interchangeable with `sclk_i` |
| ser_i | input | 1 | Serial data into the first stage |
| par_i | input | N | Parallel word; bit 0 is the first stage |
| q_o | output | 1 | Last stage |
| q_n_o | output | 1 | Inverse of the last stage |

## Verification
The checker examines the synchronised controls against the stage contents on every cycle:
- a load cycle leaves the stages equal to the synchronised word;
- a detected edge shifts them by exactly one place;
- every other cycle leaves them unchanged;
- edges never come two cycles in a row;
- the outputs stay complementary, and reset clears the stages.

The checker cannot show the parts of the behaviour that depend on the pins:
- that the OR of the clock and the inhibit is the true shift source;
- that an inhibit held high masks the clock;
- the three-cycle latency from the pins;
- the bit order across a full word.

The bench shows these by sweeping every 8-bit parallel word, shifting each one out with either input acting as the clock.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef struct packed {
    logic load_n;
    logic sclk;
    logic hold;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // Reset value: shift mode and effective clock high, so leaving reset
  // never looks like a rising edge and never loads.
  localparam ctrl_t CTRL_RST = '{load_n: 1'b1, sclk: 1'b1, hold: 1'b1};
endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/piso_edge.sv
module piso_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic hold_s,
  output logic rise
);
  logic eff_clk;
  logic eff_clk_d;

  // Either input acts as the clock; the other acts as its gate.
  assign eff_clk = sclk_s | hold_s;

  always_ff @(posedge clk) begin
    if (!rst_n) eff_clk_d <= 1'b1;
    else        eff_clk_d <= eff_clk;
  end

  assign rise = eff_clk & ~eff_clk_d;
endmodule

// File: rtl/piso_stages.sv
module piso_stages #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_n_s,
  input  logic         shift_rise,
  input  logic         ser_s,
  input  logic [N-1:0] par_s,
  output logic [N-1:0] stage
);
  always_ff @(posedge clk) begin
    if (!rst_n)             stage <= '0;
    else if (!load_n_s)     stage <= par_s;
    else if (shift_rise)    stage <= {stage[N-2:0], ser_s};
  end
endmodule

// File: rtl/piso_shift_inh.sv
module piso_shift_inh
  import piso_pkg::*;
#(
  parameter int N = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_n_i,
  input  logic         sclk_i,
  input  logic         hold_i,
  input  logic         ser_i,
  input  logic [N-1:0] par_i,
  output logic         q_o,
  output logic         q_n_o
);
  localparam int DATA_W = N + 1;

  ctrl_t             ctrl_raw;
  ctrl_t             ctrl_s;
  logic [DATA_W-1:0] data_s;
  logic              load_n_s;
  logic              ser_s;
  logic [N-1:0]      par_s;
  logic              shift_rise;
  logic [N-1:0]      stage;

  assign ctrl_raw = '{load_n: load_n_i, sclk: sclk_i, hold: hold_i};

  piso_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_RST)) ctrl_sync_i (
    .clk(clk), .rst_n(rst_n), .d(ctrl_raw), .q(ctrl_s)
  );

  // Data rides the same chain depth so it stays aligned with the controls.
  piso_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) data_sync_i (
    .clk(clk), .rst_n(rst_n), .d({ser_i, par_i}), .q(data_s)
  );

  assign load_n_s = ctrl_s.load_n;
  assign ser_s    = data_s[N];
  assign par_s    = data_s[N-1:0];

  piso_edge edge_i (
    .clk(clk), .rst_n(rst_n), .sclk_s(ctrl_s.sclk), .hold_s(ctrl_s.hold),
    .rise(shift_rise)
  );

  piso_stages #(.N(N)) stages_i (
    .clk(clk), .rst_n(rst_n), .load_n_s(load_n_s), .shift_rise(shift_rise),
    .ser_s(ser_s), .par_s(par_s), .stage(stage)
  );

  assign q_o   = stage[N-1];
  assign q_n_o = ~stage[N-1];
endmodule

// File: rtl/piso_shift_inh_chk.sv
module piso_shift_inh_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         q_o,
  input logic         q_n_o,
  input logic         load_n_s,
  input logic         shift_rise,
  input logic         ser_s,
  input logic [N-1:0] par_s,
  input logic [N-1:0] stage
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (stage == '0 && !q_o && q_n_o)); // R1

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n_s |=> stage == $past(par_s)); // R2

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_n_s && shift_rise) |=> stage == $past(par_s)); // R3

  AST_SHIFT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n_s && shift_rise) |=> stage == {$past(stage[N-2:0]), $past(ser_s)}); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n_s && !shift_rise) |=> $stable(stage)); // R7

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_rise |=> !shift_rise); // R7

  AST_OUT_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    q_n_o == !q_o); // R8
endmodule

bind piso_shift_inh piso_shift_inh_chk #(.N(N)) chk_i (
  .clk(clk), .rst_n(rst_n), .q_o(q_o), .q_n_o(q_n_o),
  .load_n_s(load_n_s), .shift_rise(shift_rise), .ser_s(ser_s),
  .par_s(par_s), .stage(stage)
);

// File: tb/piso_shift_inh_tb.sv
module piso_shift_inh_tb_top;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_n_i = 1'b1;
  logic         sclk_i = 1'b0;
  logic         hold_i = 1'b0;
  logic         ser_i = 1'b0;
  logic [N-1:0] par_i = '0;
  logic         q_o;
  logic         q_n_o;

  int vectors = 0;
  int fails = 0;

  always #4 clk = ~clk;

  piso_shift_inh #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_n_i(load_n_i), .sclk_i(sclk_i),
    .hold_i(hold_i), .ser_i(ser_i), .par_i(par_i), .q_o(q_o), .q_n_o(q_n_o)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic chk_out(input string req, input logic exp);
    chk(req, q_o, exp);
    chk("R8", q_n_o, ~exp);
  endtask

  // Drive just after a falling edge, then wait for three rising edges (R9).
  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic load_word(input logic [N-1:0] w);
    par_i = w;
    load_n_i = 1'b0;
    settle();
    load_n_i = 1'b1;
    settle();
  endtask

  // One shift using either input as the active clock.
  task automatic pulse(input bit use_hold, input logic s);
    ser_i = s;
    if (use_hold) hold_i = 1'b1; else sclk_i = 1'b1;
    settle();
    if (use_hold) hold_i = 1'b0; else sclk_i = 1'b0;
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_out("R1", 1'b0);
    rst_n = 1'b1;
    settle();
    chk_out("R1", 1'b0);

    // Exhaustive sweep: load every word, then shift it out through the last stage.
    for (int v = 0; v < 256; v++) begin
      logic [N-1:0] w;
      logic [8:0]   sbits;
      bit           via_hold;
      w = N'(v);
      sbits = {~w, w[0]};
      via_hold = v[0];
      load_word(w);
      chk_out("R2", w[N-1]);
      for (int k = 1; k <= 9; k++) begin
        pulse(via_hold, sbits[k-1]);
        chk_out(via_hold ? "R5" : "R4", (k < 8) ? w[N-1-k] : sbits[k-8]);
      end
    end

    // R10: with the load control high, changes on the parallel word are ignored.
    load_word(8'h80);
    par_i = 8'h00;
    settle();
    chk_out("R10", 1'b1);

    // R6: with hold high, clock pulses do not shift.
    load_word(8'h80);
    hold_i = 1'b1;
    settle();
    chk_out("R5", 1'b0);
    load_word(8'h80);
    for (int k = 0; k < 4; k++) begin
      sclk_i = 1'b1; settle();
      sclk_i = 1'b0; settle();
      chk_out("R6", 1'b1);
    end
    hold_i = 1'b0;
    settle();
    chk_out("R7", 1'b1);

    // R6: with the clock high, hold pulses do not shift.
    sclk_i = 1'b1;
    settle();
    chk_out("R4", 1'b0);
    load_word(8'h80);
    for (int k = 0; k < 4; k++) begin
      hold_i = 1'b1; settle();
      hold_i = 1'b0; settle();
      chk_out("R6", 1'b1);
    end
    sclk_i = 1'b0;
    settle();
    chk_out("R7", 1'b1);

    // R3: during a load, clock, hold and serial activity are ignored.
    par_i = 8'h80;
    load_n_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      ser_i = k[0];
      sclk_i = 1'b1; settle();
      chk_out("R3", 1'b1);
      sclk_i = 1'b0; hold_i = 1'b1; settle();
      chk_out("R3", 1'b1);
      hold_i = 1'b0; settle();
    end

    // R3: a load and a shift edge that arrive together resolve to the load.
    load_n_i = 1'b1;
    settle();
    par_i = 8'h80;
    ser_i = 1'b0;
    load_n_i = 1'b0;
    sclk_i = 1'b1;
    settle();
    load_n_i = 1'b1;
    settle();
    chk_out("R3", 1'b1);
    sclk_i = 1'b0;
    settle();
    chk_out("R7", 1'b1);

    // R9: latency of exactly three rising system clock edges.
    load_word(8'h40);
    ser_i = 1'b0;
    sclk_i = 1'b1;
    @(negedge clk);
    chk_out("R9", 1'b0);
    @(negedge clk);
    chk_out("R9", 1'b0);
    @(negedge clk);
    chk_out("R9", 1'b1);
    sclk_i = 1'b0;
    settle();

    // R1: reset in the middle of operation clears the register.
    load_word(8'hFF);
    rst_n = 1'b0;
    @(negedge clk);
    chk_out("R1", 1'b0);
    rst_n = 1'b1;
    settle();
    chk_out("R1", 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule